// File: doc/BRIEF.md
# Power-up configuration download sequencer

This block rebuilds a chip's volatile configuration from a nonvolatile word store each time the supply becomes valid. Every configuration word sits in a two-stage register: a staging copy and an active copy that drives the rest of the chip. The sequencer waits for a digital supply-good indication, which reports that the supply has crossed its lockout level. It then reads the stored words one after another into the staging copies and leaves the active copies alone. When the last word has landed, one commit pulse copies every staging register into its active register in the same clock edge.

The commit completes the configuration download. From that point host bus accesses are acknowledged, and until then they are refused. After a settling delay of 0.5 ms the sequencer reads one more word, the first state definition, from the store and hands it to the sequencing engine. It then raises its done flag. When done, a host reload command repeats the whole download, which restores the programmed configuration. Losing supply-good at any time sends the sequencer back to idle.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `supply_ok` is low, `pdo_weak_pd` is 1, `dl_done` is 0 and every `host_req` is answered with `host_nack`=1 and `host_ack`=0.
- R2: Counting edge 0 as the first clock edge that samples `supply_ok` high from idle, or `host_reload` high while done, the block presents `nv_rd_en`=1 with `nv_addr`=i after edge i, for words i = 0 to NWORDS-1. The store returns the data one cycle after the address.
- R3: `cfg_active` does not change while the staging registers are being filled. During a reload it keeps the previously committed words up to and including edge NWORDS+1.
- R4: At edge NWORDS+2 every word of `cfg_active` takes its stored value together. Word i sits at bits [i*DW +: DW].
- R5: `host_req` gets exactly one of `host_ack` or `host_nack`, in the same cycle. It gets `host_nack` from edge 0 until edge NWORDS+2 and `host_ack` after that, while the supply stays good.
- R6: With D = CLK_HZ/2000 cycles (0.5 ms), the block presents `nv_addr`=NWORDS with `nv_rd_en`=1 after edge NWORDS+D+2. At edge NWORDS+D+4, `se_def` holds that stored word and `dl_done` rises.
- R7: A `host_reload` pulse sampled while `dl_done` is 1 clears `dl_done` at edge 0, refuses host accesses, and performs a full download of the current store contents.
- R8: `supply_ok` sampled low clears `dl_done` and stops store reads at that edge. An interrupted download never raises `dl_done`, and the next rise of `supply_ok` starts a complete new download.
- R9: `host_reload` has no effect while a download is in progress; the timing of R6 is unchanged.
- R10: `dl_busy` is 1 from edge 0 until `dl_done` rises, 0 in idle, and never 1 together with `dl_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above lockout level |
| host_reload | input | 1 | Host command to repeat the download |
| host_req | input | 1 | Host bus access attempt |
| host_ack | output | 1 | Access accepted |
| host_nack | output | 1 | Access refused |
| nv_rd_en | output | 1 | Store read strobe |
| nv_addr | output | AW | Store word address |
| nv_rd_data | input | DW | Store read data, one cycle after address |
| cfg_active | output | NWORDS*DW | Active configuration words |
| se_def | output | DW | First state definition for the sequencing engine |
| dl_busy | output | 1 | Download in progress |
| dl_done | output | 1 | Download and handoff complete |
| pdo_weak_pd | output | 1 | Power outputs held in weak pull-down default |

## Verification
The bench builds the block with NWORDS=4, DW=8 and CLK_HZ=20000. These values shrink the 0.5 ms settling delay to 10 cycles, so a full download takes 19 cycles. With that, several complete downloads fit in a short run: power-up, host reload, a supply drop while done, and a supply drop during the settling wait. The small word count lets every address step of the fill be checked one by one, together with the exact edge of the commit and of the handoff.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_COMMIT,
    ST_HOLD,
    ST_FETCH_SE,
    ST_READY
  } boot_state_e;

endpackage

// File: rtl/boot_fsm.sv
module boot_fsm
  import cfg_boot_pkg::*;
#(
  parameter int NWORDS    = 16,
  parameter int DELAY_CYC = 50000,
  localparam int AW = $clog2(NWORDS + 1),
  localparam int IW = $clog2(NWORDS),
  localparam int CW = $clog2(DELAY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          reload_ok,
  output boot_state_e   state,
  output boot_state_e   state_nxt,
  output logic          nv_rd_en,
  output logic [AW-1:0] nv_addr,
  output logic          fill_we,
  output logic [IW-1:0] fill_idx,
  output logic          commit,
  output logic          se_cap
);

  logic [AW-1:0] iss_idx;
  logic          iss_en;
  logic          pend_v;
  logic [IW-1:0] pend_idx;
  logic [CW-1:0] dly_cnt;
  logic          se_pend;

  assign iss_en   = (state == ST_FILL) && (iss_idx < AW'(NWORDS));
  assign nv_rd_en = iss_en || (state == ST_FETCH_SE);
  assign nv_addr  = (state == ST_FETCH_SE) ? AW'(NWORDS) : iss_idx;
  assign fill_we  = pend_v && (state == ST_FILL);
  assign fill_idx = pend_idx;
  assign commit   = (state == ST_COMMIT);
  assign se_cap   = se_pend && (state == ST_READY);

  // next-state logic
  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:     if (supply_ok) state_nxt = ST_FILL;
      ST_FILL:     if (pend_v && pend_idx == IW'(NWORDS - 1)) state_nxt = ST_COMMIT;
      ST_COMMIT:   state_nxt = ST_HOLD;
      ST_HOLD:     if (dly_cnt == CW'(DELAY_CYC - 1)) state_nxt = ST_FETCH_SE;
      ST_FETCH_SE: state_nxt = ST_READY;
      ST_READY:    if (reload_ok) state_nxt = ST_FILL;
      default:     state_nxt = ST_IDLE;
    endcase
    if (!supply_ok) state_nxt = ST_IDLE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      iss_idx  <= '0;
      pend_v   <= 1'b0;
      pend_idx <= '0;
      dly_cnt  <= '0;
      se_pend  <= 1'b0;
    end else begin
      state    <= state_nxt;
      if (state != ST_FILL) iss_idx <= '0;
      else if (iss_en)      iss_idx <= iss_idx + 1'b1;
      pend_v   <= iss_en;
      if (iss_en) pend_idx <= iss_idx[IW-1:0];
      if (state != ST_HOLD) dly_cnt <= '0;
      else                  dly_cnt <= dly_cnt + 1'b1;
      se_pend  <= (state == ST_FETCH_SE) && supply_ok;
    end
  end

endmodule

// File: rtl/boot_latch_bank.sv
module boot_latch_bank #(
  parameter int NWORDS = 16,
  parameter int DW     = 8,
  localparam int IW = $clog2(NWORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IW-1:0]        widx,
  input  logic [DW-1:0]        wdata,
  input  logic                 commit,
  output logic [NWORDS*DW-1:0] active
);

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [DW-1:0] stage_q;
    logic [DW-1:0] act_q;
    logic          stage_en;

    assign stage_en = we && (widx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        act_q   <= '0;
      end else begin
        if (stage_en) stage_q <= wdata;
        if (commit)   act_q   <= stage_q;
      end
    end

    assign active[g*DW +: DW] = act_q;
  end

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cfg_boot_pkg::*;
#(
  parameter int NWORDS = 16,
  parameter int DW     = 8,
  parameter int CLK_HZ = 100_000_000,
  localparam int AW        = $clog2(NWORDS + 1),
  localparam int IW        = $clog2(NWORDS),
  localparam int DELAY_CYC = CLK_HZ / 2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 supply_ok,
  input  logic                 host_reload,
  input  logic                 host_req,
  output logic                 host_ack,
  output logic                 host_nack,
  output logic                 nv_rd_en,
  output logic [AW-1:0]        nv_addr,
  input  logic [DW-1:0]        nv_rd_data,
  output logic [NWORDS*DW-1:0] cfg_active,
  output logic [DW-1:0]        se_def,
  output logic                 dl_busy,
  output logic                 dl_done,
  output logic                 pdo_weak_pd
);

  boot_state_e   st;
  boot_state_e   st_nxt;
  logic          fill_we;
  logic [IW-1:0] fill_idx;
  logic          commit;
  logic          se_cap;
  logic          cfg_ready;
  logic          done_nxt;

  boot_fsm #(.NWORDS(NWORDS), .DELAY_CYC(DELAY_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .reload_ok (host_reload && dl_done),
    .state     (st),
    .state_nxt (st_nxt),
    .nv_rd_en  (nv_rd_en),
    .nv_addr   (nv_addr),
    .fill_we   (fill_we),
    .fill_idx  (fill_idx),
    .commit    (commit),
    .se_cap    (se_cap)
  );

  boot_latch_bank #(.NWORDS(NWORDS), .DW(DW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (fill_we),
    .widx   (fill_idx),
    .wdata  (nv_rd_data),
    .commit (commit),
    .active (cfg_active)
  );

  assign done_nxt = (st_nxt == ST_READY) && (dl_done || se_cap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_done <= 1'b0;
      se_def  <= '0;
    end else begin
      dl_done <= done_nxt;
      if (se_cap) se_def <= nv_rd_data;
    end
  end

  assign cfg_ready   = (st == ST_HOLD) || (st == ST_FETCH_SE) || (st == ST_READY);
  assign host_ack    = host_req && cfg_ready;
  assign host_nack   = host_req && !cfg_ready;
  assign dl_busy     = (st != ST_IDLE) && !dl_done;
  assign pdo_weak_pd = !supply_ok;

endmodule

// File: rtl/cfg_boot_seq_chk.sv
module cfg_boot_seq_chk
  import cfg_boot_pkg::*;
#(
  parameter int NWORDS = 16,
  parameter int DW     = 8,
  parameter int AW     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 supply_ok,
  input logic                 host_req,
  input logic                 host_ack,
  input logic                 host_nack,
  input logic                 nv_rd_en,
  input logic [AW-1:0]        nv_addr,
  input logic [NWORDS*DW-1:0] cfg_active,
  input logic                 dl_done,
  input logic                 dl_busy,
  input boot_state_e          st
);

  assert_nodone_nosupply_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !dl_done);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL && nv_rd_en && $past(st == ST_FILL && nv_rd_en))
      |-> nv_addr == AW'($past(nv_addr) + 1'b1));

  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL) |=> $stable(cfg_active));

  assert_one_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> (host_ack != host_nack));

  assert_ack_when_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_done && host_req) |-> host_ack);

  assert_se_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH_SE) |-> (nv_rd_en && nv_addr == AW'(NWORDS)));

  assert_idle_on_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (st == ST_IDLE));

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dl_done && dl_busy));

endmodule

bind cfg_boot_seq cfg_boot_seq_chk #(.NWORDS(NWORDS), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .host_req   (host_req),
  .host_ack   (host_ack),
  .host_nack  (host_nack),
  .nv_rd_en   (nv_rd_en),
  .nv_addr    (nv_addr),
  .cfg_active (cfg_active),
  .dl_done    (dl_done),
  .dl_busy    (dl_busy),
  .st         (st)
);

// File: tb/cfg_boot_seq_bench.sv
module cfg_boot_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NW  = 4;
  localparam int DW  = 8;
  localparam int HZ  = 20000;
  localparam int DLY = HZ / 2000;
  localparam int AW  = $clog2(NW + 1);
  localparam int LAT = NW + DLY + 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             supply_ok = 1'b0;
  logic             host_reload = 1'b0;
  logic             host_req = 1'b0;
  logic             host_ack, host_nack, nv_rd_en, dl_busy, dl_done, pdo_weak_pd;
  logic [AW-1:0]    nv_addr;
  logic [DW-1:0]    nv_rd_data;
  logic [NW*DW-1:0] cfg_active;
  logic [DW-1:0]    se_def;

  logic [DW-1:0] mem [0:NW];

  typedef struct {
    logic [NW*DW-1:0] cfg;
    logic [DW-1:0]    se;
    int               t0;
  } item_t;

  item_t sb_q[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    prev_done = 1'b0;
  logic [NW*DW-1:0] cfg_a;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc++;

  always @(posedge clk) if (nv_rd_en) nv_rd_data <= mem[nv_addr];

  cfg_boot_seq #(.NWORDS(NW), .DW(DW), .CLK_HZ(HZ)) u_cfg_boot_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .host_reload(host_reload),
    .host_req(host_req), .host_ack(host_ack), .host_nack(host_nack),
    .nv_rd_en(nv_rd_en), .nv_addr(nv_addr), .nv_rd_data(nv_rd_data),
    .cfg_active(cfg_active), .se_def(se_def), .dl_busy(dl_busy),
    .dl_done(dl_done), .pdo_weak_pd(pdo_weak_pd)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NW*DW-1:0] pack_mem();
    logic [NW*DW-1:0] v;
    for (int i = 0; i < NW; i++) v[i*DW +: DW] = mem[i];
    return v;
  endfunction

  // driver: pushes the expected result of the download it launches
  task automatic launch();
    item_t it;
    it.cfg = pack_mem();
    it.se  = mem[NW];
    it.t0  = cyc;
    sb_q.push_back(it);
  endtask

  task automatic fill_mem(input logic [DW-1:0] base, input logic [DW-1:0] se);
    for (int i = 0; i < NW; i++) mem[i] = base + DW'(i * 7);
    mem[NW] = se;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3 * LAT && !dl_done; i++) step(1);
    step(1);
  endtask

  // monitor: pops expected item on each rise of dl_done
  always @(negedge clk) begin
    if (rst_n && dl_done && !prev_done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8 unexpected done", 64'(dl_done), 64'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(cfg_active == it.cfg, "R4/R7 active words", 64'(cfg_active), 64'(it.cfg));
        chk(se_def == it.se, "R6 state definition", 64'(se_def), 64'(it.se));
        chk(cyc - it.t0 == LAT, "R6/R9 done timing", 64'(cyc - it.t0), 64'(LAT));
      end
    end
    prev_done = dl_done;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fill_mem(8'h10, 8'hA5);
    step(3);
    rst_n = 1'b1;
    host_req = 1'b1;
    step(2);
    // R1, R10 reset / no-supply state
    chk(pdo_weak_pd == 1'b1, "R1 weak pull-down", 64'(pdo_weak_pd), 64'd1);
    chk(host_nack && !host_ack, "R1 nack before supply", 64'({host_ack, host_nack}), 64'b01);
    chk(!dl_done && !dl_busy, "R10 idle flags", 64'({dl_done, dl_busy}), 64'b00);
    chk(!nv_rd_en, "R1 no reads", 64'(nv_rd_en), 64'd0);

    // power-up download
    supply_ok = 1'b1;
    launch();
    step(1);
    chk(!pdo_weak_pd, "R1 pull-down released", 64'(pdo_weak_pd), 64'd0);
    chk(dl_busy, "R10 busy", 64'(dl_busy), 64'd1);
    for (int i = 0; i < NW; i++) begin
      chk(nv_rd_en && nv_addr == AW'(i), "R2 fill address", 64'(nv_addr), 64'(i));
      step(1);
    end
    step(1);
    chk(cfg_active == '0, "R3 active held", 64'(cfg_active), 64'd0);
    chk(host_nack, "R5 nack before commit", 64'(host_nack), 64'd1);
    step(1);
    chk(cfg_active == pack_mem(), "R4 commit", 64'(cfg_active), 64'(pack_mem()));
    chk(host_ack && !host_nack, "R5 ack after commit", 64'({host_ack, host_nack}), 64'b10);
    step(DLY);
    chk(nv_rd_en && nv_addr == AW'(NW), "R6 state def address", 64'(nv_addr), 64'(NW));
    step(1);
    chk(!dl_done, "R6 done not early", 64'(dl_done), 64'd0);
    wait_done();
    chk(!dl_busy, "R10 busy low when done", 64'(dl_busy), 64'd0);

    // host reload with new store contents; extra reload mid-download ignored
    cfg_a = pack_mem();
    fill_mem(8'h40, 8'h3C);
    host_reload = 1'b1;
    launch();
    step(1);
    host_reload = 1'b0;
    chk(!dl_done && dl_busy, "R7 done cleared", 64'({dl_done, dl_busy}), 64'b01);
    chk(host_nack, "R7 host refused", 64'(host_nack), 64'd1);
    step(2);
    host_reload = 1'b1;  // R9 ignored during fill
    step(1);
    host_reload = 1'b0;
    step(2);
    chk(cfg_active == cfg_a, "R3 old config kept", 64'(cfg_active), 64'(cfg_a));
    step(1);
    chk(cfg_active == pack_mem(), "R7 reloaded config", 64'(cfg_active), 64'(pack_mem()));
    wait_done();

    // supply drop while done
    fill_mem(8'h81, 8'h5A);
    supply_ok = 1'b0;
    step(1);
    chk(!dl_done && !nv_rd_en, "R8 drop clears done", 64'({dl_done, nv_rd_en}), 64'b00);
    chk(pdo_weak_pd && host_nack, "R1 drop pull-down", 64'({pdo_weak_pd, host_nack}), 64'b11);
    chk(!dl_busy, "R10 idle after drop", 64'(dl_busy), 64'd0);
    step(3);

    // supply drop in settling wait
    supply_ok = 1'b1;
    launch();
    step(10);
    supply_ok = 1'b0;
    void'(sb_q.pop_back());
    step(1);
    chk(!dl_busy && !nv_rd_en, "R8 abort to idle", 64'({dl_busy, nv_rd_en}), 64'b00);
    step(25);
    chk(!dl_done, "R8 no done after abort", 64'(dl_done), 64'd0);

    supply_ok = 1'b1;
    launch();
    wait_done();
    chk(dl_done && se_def == 8'h5A, "R8 fresh download", 64'(se_def), 64'h5A);
    chk(sb_q.size() == 0, "R8 scoreboard drained", 64'(sb_q.size()), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule